// File: doc/BRIEF.md
# Sequential Exact-Match Flow Lookup

This block resolves a packet's two header keys against a small exact-match forwarding table kept in one single-ported on-chip store. Rules sit at arbitrary slots with no ordering by key. After a lookup is accepted, the block visits one slot per clock, starting at slot 0 and moving upward. It compares both keys of the request with both keys of the slot, and only slots flagged valid can match.

The walk stops at the first matching slot. The result then gives that slot's action code and index, together with the slot's hit counter after this hit has been added. The counter saturates at its maximum value. If no valid slot matches, the walk ends at the highest valid slot and the result flags the packet to be sent to the controller. A controller installs or removes rules through a write port. That port shares the single store port, so it is held off while a walk is running.

Top module: `flow_matcher`

## Requirements
- R1: After reset, busy, done, hit and punt are all low, every slot is invalid, and a lookup ends in a punt.
- R2: A lookup is accepted on a clock where req_valid is high and busy is low. busy is high from the next clock until the result is returned. req_valid and the key inputs are ignored while busy is high.
- R3: Slots are compared in ascending index order from slot 0, one per clock. When slot k is the first match, done is high exactly k+1 clocks after the accepting clock.
- R4: When several valid slots hold the same key pair, the lowest index wins.
- R5: A slot whose valid bit is 0 never matches, even if its keys are equal to the request.
- R6: When no valid slot matches, punt is 1 and hit is 0. done then comes h+1 clocks after acceptance, where h is the highest valid index, or 0 if no slot is valid.
- R7: On a match, hit is 1, res_act holds the slot's action and res_idx holds the slot index. done is a one-clock pulse, and the result outputs stay unchanged until the next lookup is accepted.
- R8: Every match adds one to that slot's hit counter, and res_cnt reports the updated value. Installing a slot through the write port resets its counter to 0.
- R9: The hit counter stops at 2^CNT_W-1 and does not wrap.
- R10: A write (wr_en high) is applied on a clock where busy is low. wr_block equals busy. A write held during a walk is not seen by that walk and is applied on the first clock after the walk ends.
- R11: hit and punt are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request |
| req_key_a | input | AW | First header key |
| req_key_b | input | BW | Second header key |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-clock result pulse |
| hit | output | 1 | Last lookup matched |
| punt | output | 1 | Last lookup missed; send to controller |
| res_act | output | TW | Action of matching slot |
| res_idx | output | IW | Index of matching slot |
| res_cnt | output | CW | Updated hit counter of matching slot |
| wr_en | input | 1 | Controller slot write |
| wr_idx | input | IW | Slot to write |
| wr_valid | input | 1 | Valid bit to store |
| wr_key_a | input | AW | First key to store |
| wr_key_b | input | BW | Second key to store |
| wr_act | input | TW | Action to store |
| wr_block | output | 1 | Write held off by a walk |

## Verification
The bench builds the block with eight slots, 8-bit keys and actions, and a 3-bit hit counter. The narrow counter makes saturation reachable after seven hits on one slot. Random keys are drawn from a range of four values, so duplicate rules, shadowed slots and invalid slots with matching keys come up often. The shallow table keeps every latency, from 1 to 8 clocks, within reach. Directed cases cover a write held during a walk and request pulses that arrive while busy.

// File: rtl/flowtab_pkg.sv
package flowtab_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SCAN = 1'b1
   } ftm_state_e;
endpackage

// File: rtl/ftm_store.sv
// Slot storage behind one address port: key, action and counter arrays,
// with the valid bits in flops so the top index can be derived.
module ftm_store #(
   parameter int DEPTH = 16,
   parameter int AW    = 16,
   parameter int BW    = 16,
   parameter int TW    = 8,
   parameter int CW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IW-1:0]    addr,
   input  logic             we_entry,
   input  logic             we_cnt,
   input  logic             w_valid,
   input  logic [AW-1:0]    w_a,
   input  logic [BW-1:0]    w_b,
   input  logic [TW-1:0]    w_act,
   input  logic [CW-1:0]    w_cnt,
   output logic             r_valid,
   output logic [AW-1:0]    r_a,
   output logic [BW-1:0]    r_b,
   output logic [TW-1:0]    r_act,
   output logic [CW-1:0]    r_cnt,
   output logic [DEPTH-1:0] valid_vec
);
   logic [AW-1:0] mem_a   [DEPTH];
   logic [BW-1:0] mem_b   [DEPTH];
   logic [TW-1:0] mem_act [DEPTH];
   logic [CW-1:0] mem_cnt [DEPTH];

   always_ff @(posedge clk) begin
      if (we_entry) begin
         mem_a[addr]   <= w_a;
         mem_b[addr]   <= w_b;
         mem_act[addr] <= w_act;
         mem_cnt[addr] <= '0;
      end else if (we_cnt) begin
         mem_cnt[addr] <= w_cnt;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_vld
      always_ff @(posedge clk) begin
         if (!rst_n)
            valid_vec[g] <= 1'b0;
         else if (we_entry && addr == IW'(g))
            valid_vec[g] <= w_valid;
      end
   end

   assign r_valid = valid_vec[addr];
   assign r_a     = mem_a[addr];
   assign r_b     = mem_b[addr];
   assign r_act   = mem_act[addr];
   assign r_cnt   = mem_cnt[addr];
endmodule

// File: rtl/ftm_probe.sv
// Per-slot compare and saturating counter step.
module ftm_probe #(
   parameter int AW = 16,
   parameter int BW = 16,
   parameter int CW = 16
) (
   input  logic          r_valid,
   input  logic [AW-1:0] r_a,
   input  logic [BW-1:0] r_b,
   input  logic [CW-1:0] r_cnt,
   input  logic [AW-1:0] key_a,
   input  logic [BW-1:0] key_b,
   output logic          match,
   output logic [CW-1:0] cnt_next
);
   localparam logic [CW-1:0] CMAX = {CW{1'b1}};

   assign match    = r_valid && (r_a == key_a) && (r_b == key_b);
   assign cnt_next = (r_cnt == CMAX) ? CMAX : r_cnt + CW'(1);
endmodule

// File: rtl/ftm_seq.sv
// Walk sequencer: accepts a lookup, steps the slot index, ends on the
// first match or at the highest valid slot, and holds the result.
module ftm_seq
   import flowtab_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 16,
   parameter int BW    = 16,
   parameter int TW    = 8,
   parameter int CW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_key_a,
   input  logic [BW-1:0] req_key_b,
   input  logic          match,
   input  logic [TW-1:0] r_act,
   input  logic [CW-1:0] cnt_next,
   input  logic [IW-1:0] hi_idx,
   output logic          scanning,
   output logic [IW-1:0] scan_idx,
   output logic [AW-1:0] cap_a,
   output logic [BW-1:0] cap_b,
   output logic          done,
   output logic          hit,
   output logic          punt,
   output logic [TW-1:0] res_act,
   output logic [IW-1:0] res_idx,
   output logic [CW-1:0] res_cnt
);
   ftm_state_e state;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         scan_idx <= '0;
         cap_a    <= '0;
         cap_b    <= '0;
         done     <= 1'b0;
         hit      <= 1'b0;
         punt     <= 1'b0;
         res_act  <= '0;
         res_idx  <= '0;
         res_cnt  <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  state    <= ST_SCAN;
                  scan_idx <= '0;
                  cap_a    <= req_key_a;
                  cap_b    <= req_key_b;
                  hit      <= 1'b0;
                  punt     <= 1'b0;
                  res_act  <= '0;
                  res_idx  <= '0;
                  res_cnt  <= '0;
               end
            end
            ST_SCAN: begin
               if (match) begin
                  state   <= ST_IDLE;
                  done    <= 1'b1;
                  hit     <= 1'b1;
                  res_act <= r_act;
                  res_idx <= scan_idx;
                  res_cnt <= cnt_next;
               end else if (scan_idx == hi_idx) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
                  punt  <= 1'b1;
               end else begin
                  scan_idx <= scan_idx + IW'(1);
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign scanning = (state == ST_SCAN);
endmodule

// File: rtl/flow_matcher.sv
module flow_matcher #(
   parameter int DEPTH = 16,
   parameter int AW    = 16,
   parameter int BW    = 16,
   parameter int TW    = 8,
   parameter int CW    = 16,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [AW-1:0] req_key_a,
   input  logic [BW-1:0] req_key_b,
   output logic          busy,
   output logic          done,
   output logic          hit,
   output logic          punt,
   output logic [TW-1:0] res_act,
   output logic [IW-1:0] res_idx,
   output logic [CW-1:0] res_cnt,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_idx,
   input  logic          wr_valid,
   input  logic [AW-1:0] wr_key_a,
   input  logic [BW-1:0] wr_key_b,
   input  logic [TW-1:0] wr_act,
   output logic          wr_block
);
   if (DEPTH < 2 || (1 << IW) != DEPTH) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (AW < 1 || BW < 1 || TW < 1 || CW < 1) begin : g_bad_width
      $error("key, action and counter widths must be positive");
   end

   logic [IW-1:0]    scan_idx, port_addr, hi_idx;
   logic [AW-1:0]    cap_a, r_a;
   logic [BW-1:0]    cap_b, r_b;
   logic [TW-1:0]    r_act;
   logic [CW-1:0]    r_cnt, cnt_next;
   logic [DEPTH-1:0] valid_vec;
   logic             r_valid, match, scanning, we_entry, we_cnt;

   // One port: the walk owns it while scanning, the controller otherwise.
   assign port_addr = scanning ? scan_idx : wr_idx;
   assign we_entry  = wr_en && !scanning;
   assign we_cnt    = scanning && match;

   always_comb begin
      hi_idx = '0;
      for (int i = 0; i < DEPTH; i++)
         if (valid_vec[i]) hi_idx = IW'(i);
   end

   ftm_store #(.DEPTH(DEPTH), .AW(AW), .BW(BW), .TW(TW), .CW(CW)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (port_addr),
      .we_entry (we_entry),
      .we_cnt   (we_cnt),
      .w_valid  (wr_valid),
      .w_a      (wr_key_a),
      .w_b      (wr_key_b),
      .w_act    (wr_act),
      .w_cnt    (cnt_next),
      .r_valid  (r_valid),
      .r_a      (r_a),
      .r_b      (r_b),
      .r_act    (r_act),
      .r_cnt    (r_cnt),
      .valid_vec(valid_vec)
   );

   ftm_probe #(.AW(AW), .BW(BW), .CW(CW)) u_probe (
      .r_valid (r_valid),
      .r_a     (r_a),
      .r_b     (r_b),
      .r_cnt   (r_cnt),
      .key_a   (cap_a),
      .key_b   (cap_b),
      .match   (match),
      .cnt_next(cnt_next)
   );

   ftm_seq #(.DEPTH(DEPTH), .AW(AW), .BW(BW), .TW(TW), .CW(CW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_valid(req_valid),
      .req_key_a(req_key_a),
      .req_key_b(req_key_b),
      .match    (match),
      .r_act    (r_act),
      .cnt_next (cnt_next),
      .hi_idx   (hi_idx),
      .scanning (scanning),
      .scan_idx (scan_idx),
      .cap_a    (cap_a),
      .cap_b    (cap_b),
      .done     (done),
      .hit      (hit),
      .punt     (punt),
      .res_act  (res_act),
      .res_idx  (res_idx),
      .res_cnt  (res_cnt)
   );

   assign busy     = scanning;
   assign wr_block = scanning;
endmodule

// File: rtl/ftm_chk.sv
module ftm_chk #(
   parameter int CW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          busy,
   input logic          done,
   input logic          hit,
   input logic          punt,
   input logic [CW-1:0] res_cnt,
   input logic          wr_block
);
   p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   p_end_with_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> ($stable(hit) && $stable(punt)));

   p_cnt_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && hit) |-> (res_cnt != '0));

   p_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_block == busy);

   p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && punt));
endmodule

bind flow_matcher ftm_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_valid(req_valid),
   .busy     (busy),
   .done     (done),
   .hit      (hit),
   .punt     (punt),
   .res_cnt  (res_cnt),
   .wr_block (wr_block)
);

// File: tb/tb_flow_matcher.sv
`timescale 1ns/1ps
module tb_flow_matcher;
   localparam int DEPTH = 8;
   localparam int AW = 8, BW = 8, TW = 8, CW = 3;
   localparam int IW = 3;
   localparam int CMAX = (1 << CW) - 1;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0;
   logic [AW-1:0] req_key_a = 0;
   logic [BW-1:0] req_key_b = 0;
   logic busy, done, hit, punt, wr_block;
   logic [TW-1:0] res_act;
   logic [IW-1:0] res_idx;
   logic [CW-1:0] res_cnt;
   logic wr_en = 0, wr_valid = 0;
   logic [IW-1:0] wr_idx = 0;
   logic [AW-1:0] wr_key_a = 0;
   logic [BW-1:0] wr_key_b = 0;
   logic [TW-1:0] wr_act = 0;

   always #2 clk = ~clk;

   flow_matcher #(.DEPTH(DEPTH), .AW(AW), .BW(BW), .TW(TW), .CW(CW)) dut (.*);

   int checks = 0, errors = 0;
   bit finished = 0;

   bit          m_v   [DEPTH];
   logic [7:0]  m_a   [DEPTH];
   logic [7:0]  m_b   [DEPTH];
   logic [7:0]  m_act [DEPTH];
   int          m_cnt [DEPTH];

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int first_hit(input logic [7:0] a, input logic [7:0] b);
      for (int i = 0; i < DEPTH; i++)
         if (m_v[i] && m_a[i] == a && m_b[i] == b) return i;
      return -1;
   endfunction

   function automatic int top_valid();
      int h = 0;
      for (int i = 0; i < DEPTH; i++) if (m_v[i]) h = i;
      return h;
   endfunction

   task automatic do_write(input int idx, input bit v, input logic [7:0] a,
                           input logic [7:0] b, input logic [7:0] act);
      @(negedge clk);
      while (busy) @(negedge clk);
      wr_en = 1; wr_idx = IW'(idx); wr_valid = v;
      wr_key_a = a; wr_key_b = b; wr_act = act;
      @(posedge clk);
      @(negedge clk);
      wr_en = 0;
      m_v[idx] = v; m_a[idx] = a; m_b[idx] = b; m_act[idx] = act; m_cnt[idx] = 0;
   endtask

   // Lookup with model prediction; noise injects a busy-time request (R2).
   task automatic lookup(input logic [7:0] a, input logic [7:0] b,
                         input string tag, input bit noise);
      int k, lat, n;
      k = first_hit(a, b);
      lat = (k >= 0) ? k + 1 : top_valid() + 1;
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1; req_key_a = a; req_key_b = b;
      @(posedge clk);
      @(negedge clk);
      req_valid = 0;
      n = 0;
      forever begin
         if (noise && n == 0 && busy) begin
            req_valid = 1; req_key_a = a ^ 8'h55; req_key_b = b ^ 8'h0F;
         end
         @(posedge clk);
         n++;
         @(negedge clk);
         req_valid = 0;
         if (done || n > 40) break;
      end
      chk(n == lat, {tag, " R3/R6 latency"}, n, lat);
      if (k >= 0) begin
         if (m_cnt[k] < CMAX) m_cnt[k]++;
         chk(hit == 1 && punt == 0, {tag, " R7 hit flag"}, hit, 1);
         chk(res_idx == IW'(k), {tag, " R4 index"}, res_idx, k);
         chk(res_act == m_act[k], {tag, " R7 action"}, res_act, m_act[k]);
         chk(res_cnt == CW'(m_cnt[k]), {tag, " R8/R9 count"}, res_cnt, m_cnt[k]);
      end else begin
         chk(punt == 1 && hit == 0, {tag, " R6 punt"}, punt, 1);
      end
      @(negedge clk);
      chk(done == 0, {tag, " R7 done pulse"}, done, 0);
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         m_v[i] = 0; m_a[i] = 0; m_b[i] = 0; m_act[i] = 0; m_cnt[i] = 0;
      end
      void'($urandom(32'd20241));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !hit && !punt, "R1 reset outputs", {busy, done, hit, punt}, 0);
      lookup(8'h00, 8'h00, "R1 empty table", 0);

      // R5: invalid slot with matching keys is skipped
      do_write(1, 0, 8'h11, 8'h22, 8'h01);
      do_write(4, 1, 8'h11, 8'h22, 8'h44);
      lookup(8'h11, 8'h22, "R5 invalid skipped", 0);
      // R4: duplicate keys, lowest index wins
      do_write(2, 1, 8'h11, 8'h22, 8'h22);
      lookup(8'h11, 8'h22, "R4 duplicate", 0);
      // R6: miss ends at highest valid slot
      lookup(8'h11, 8'h23, "R6 miss", 0);
      // R2: request pulses while busy are ignored
      do_write(6, 1, 8'h66, 8'h77, 8'h99);
      lookup(8'h66, 8'h77, "R2 busy request ignored", 1);
      // R8: write clears counter
      lookup(8'h66, 8'h77, "R8 second hit", 0);
      do_write(6, 1, 8'h66, 8'h77, 8'h98);
      lookup(8'h66, 8'h77, "R8 counter cleared", 0);
      // R9: saturation on slot 2
      for (int j = 0; j < CMAX + 2; j++) lookup(8'h11, 8'h22, "R9 saturate", 0);

      // R10: write held during a walk is not seen by it
      begin
         int n;
         do_write(7, 1, 8'hAB, 8'hCD, 8'h5A);
         @(negedge clk);
         req_valid = 1; req_key_a = 8'hAB; req_key_b = 8'hCD;
         @(posedge clk);
         @(negedge clk);
         req_valid = 0;
         wr_en = 1; wr_idx = 3'd7; wr_valid = 0;
         wr_key_a = 8'hAB; wr_key_b = 8'hCD; wr_act = 8'h00;
         chk(wr_block == 1, "R10 wr_block during walk", wr_block, 1);
         n = 0;
         forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done || n > 40) break;
         end
         chk(hit == 1 && res_idx == 3'd7, "R10 walk saw old slot", res_idx, 7);
         chk(res_act == 8'h5A, "R10 old action", res_act, 8'h5A);
         @(posedge clk);
         @(negedge clk);
         wr_en = 0;
         m_v[7] = 0; m_act[7] = 0; m_cnt[7] = 0;
         lookup(8'hAB, 8'hCD, "R10 held write applied", 0);
      end

      // Random mix with a narrow key range
      for (int it = 0; it < 400; it++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 30)
            do_write($urandom_range(0, DEPTH - 1), ($urandom_range(0, 9) < 8),
                     8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                     8'($urandom_range(0, 255)));
         else
            lookup(8'($urandom_range(0, 3)), 8'($urandom_range(0, 3)),
                   "R3 random", ($urandom_range(0, 3) == 0));
      end

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog R3 actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule